// File: doc/BRIEF.md
# Sum-of-Absolute-Difference Trace Window Aligner

This block finds the time offset at which a captured trace segment best lines up with a stored reference window. Each run begins with a `start` pulse that also latches the acceptance limit for that run. The block then takes `WIN` signed reference samples, followed by `WIN + 2*MAX_SHIFT` signed trace samples. It tries every offset from `-MAX_SHIFT` to `+MAX_SHIFT`. At each offset it adds up the absolute differences between the offset trace window and the reference, and it keeps the smallest total along with its offset.

When the search ends, the block raises `done` and presents the winning offset and its total. It also raises `match` when that total does not exceed the limit latched for the run. A failed match still reports the offset and the total, so a host can discard the trace or log how close it came. The limit and the reference are loaded again on every run. This lets a coarse pass over one part of the trace, with a generous limit, be followed by a strict pass over another part.

Top module: `sad_window_aligner`

## Requirements
- R1: After reset, `done`, `match`, `best_shift` and `best_sad` are all 0.
- R2: A `start` pulse latches `cfg_max_sad`. The block then accepts exactly `WIN` reference samples (cycles with `ref_valid` high), followed by exactly `WIN+2*MAX_SHIFT` segment samples (cycles with `seg_valid` high). Segment sample j lines up with reference sample i at shift s when j = i + s + MAX_SHIFT.
- R3: The score for a shift is the sum over the window of |seg - ref|, with samples read as two's-complement. The score is `8 + log2(WIN)` bits wide and never wraps, even when every term is 255.
- R4: `best_shift` (two's complement) is the shift in -MAX_SHIFT..+MAX_SHIFT that has the lowest score, and `best_sad` is that score.
- R5: When scores tie, the shift with the smaller magnitude wins. If the magnitudes are also equal, the negative shift wins.
- R6: `match` is 1 when `best_sad` <= the latched limit and 0 otherwise. `best_shift` and `best_sad` are reported in both cases.
- R7: `done` rises exactly (2*MAX_SHIFT+1)*WIN clock cycles after the clock edge that accepts the last segment sample.
- R8: `done`, `match`, `best_shift` and `best_sad` hold steady until the next `start`. In the cycle after `start`, `done` is 0.
- R9: `seg_valid` has no effect while reference samples are being taken, and `ref_valid` has no effect while segment samples are being taken.
- R10: Consecutive runs over the same data with different limits give each run its own `match` decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; latches `cfg_max_sad` |
| cfg_max_sad | input | SAD_W | Largest score accepted as a match |
| ref_valid | input | 1 | Reference sample strobe |
| ref_data | input | SW | Reference sample, signed |
| seg_valid | input | 1 | Trace segment sample strobe |
| seg_data | input | SW | Trace segment sample, signed |
| done | output | 1 | Result valid, held until next start |
| match | output | 1 | Best score within the limit |
| best_shift | output | SH_W | Winning shift, signed |
| best_sad | output | SAD_W | Score of the winning shift |

## Verification
The assertions assume that `start` is a single-cycle pulse and that a run is never restarted in the middle of the search. Under that assumption, a raised `done` can only come from a completed search, and the best score can only fall while offsets are being scanned. The bench pulses `start` for exactly one cycle and always waits for `done` before starting again. It raises the strobe for the wrong phase only on purpose, during the loading stages, so that the rule that such strobes are ignored gets exercised without breaking those assumptions.

// File: rtl/sad_align_pkg.sv
package sad_align_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REF,
    ST_SEG,
    ST_SCAN,
    ST_DONE
  } aln_state_t;

  // Magnitude of the difference of two sign-extended samples.
  function automatic int unsigned sad_abs(input int a, input int b);
    int d;
    d = a - b;
    return (d < 0) ? int'(-d) : d;
  endfunction

  // Candidate order 0, -1, +1, -2, +2, ... so that a strict "less than"
  // update leaves ties with the smaller magnitude, then the negative shift.
  function automatic int cand_to_shift(input int c);
    if (c == 0) return 0;
    else if (c % 2 == 1) return -((c + 1) / 2);
    else return c / 2;
  endfunction

endpackage

// File: rtl/sad_sample_store.sv
module sad_sample_store #(
  parameter int SW      = 8,
  parameter int WIN     = 16,
  parameter int SEG_LEN = 24,
  localparam int IW_R   = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int IW_S   = $clog2(SEG_LEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            ref_we,
  input  logic [SW-1:0]   ref_d,
  input  logic            seg_we,
  input  logic [SW-1:0]   seg_d,
  input  logic [IW_R-1:0] ref_ra,
  input  logic [IW_S-1:0] seg_ra,
  output logic [SW-1:0]   ref_q,
  output logic [SW-1:0]   seg_q,
  output logic            ref_last,
  output logic            seg_last
);

  logic [SW-1:0]   ref_mem [WIN];
  logic [SW-1:0]   seg_mem [SEG_LEN];
  logic [IW_R-1:0] ref_wp;
  logic [IW_S-1:0] seg_wp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_wp <= '0;
      seg_wp <= '0;
    end else if (clr) begin
      ref_wp <= '0;
      seg_wp <= '0;
    end else begin
      if (ref_we) ref_wp <= ref_wp + 1'b1;
      if (seg_we) seg_wp <= seg_wp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ref_we) ref_mem[ref_wp] <= ref_d;
    if (seg_we) seg_mem[seg_wp] <= seg_d;
  end

  assign ref_q    = ref_mem[ref_ra];
  assign seg_q    = seg_mem[seg_ra];
  assign ref_last = (ref_wp == IW_R'(WIN - 1));
  assign seg_last = (seg_wp == IW_S'(SEG_LEN - 1));

endmodule

// File: rtl/sad_scan_ctrl.sv
module sad_scan_ctrl
  import sad_align_pkg::*;
#(
  parameter int WIN       = 16,
  parameter int MAX_SHIFT = 4,
  localparam int NCAND    = 2 * MAX_SHIFT + 1,
  localparam int EW       = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int CW       = $clog2(NCAND)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ref_valid,
  input  logic          seg_valid,
  input  logic          ref_last,
  input  logic          seg_last,
  output logic          ref_we,
  output logic          seg_we,
  output logic          scan_step,
  output logic          win_end,
  output logic          scan_last,
  output logic          first_cand,
  output logic [EW-1:0] elem,
  output logic [CW-1:0] cand,
  output logic          done
);

  aln_state_t state;

  assign ref_we     = (state == ST_REF) && ref_valid && !start;
  assign seg_we     = (state == ST_SEG) && seg_valid && !start;
  assign scan_step  = (state == ST_SCAN) && !start;
  assign win_end    = (elem == EW'(WIN - 1));
  assign scan_last  = win_end && (cand == CW'(NCAND - 1));
  assign first_cand = (cand == '0);
  assign done       = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      elem  <= '0;
      cand  <= '0;
    end else if (start) begin
      state <= ST_REF;
      elem  <= '0;
      cand  <= '0;
    end else begin
      unique case (state)
        ST_REF:  if (ref_we && ref_last) state <= ST_SEG;
        ST_SEG:  if (seg_we && seg_last) state <= ST_SCAN;
        ST_SCAN: begin
          if (win_end) begin
            elem <= '0;
            if (scan_last) state <= ST_DONE;
            else cand <= cand + 1'b1;
          end else begin
            elem <= elem + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sad_best_track.sv
module sad_best_track
  import sad_align_pkg::*;
#(
  parameter int SW    = 8,
  parameter int SAD_W = 12,
  parameter int SH_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   step,
  input  logic                   win_end,
  input  logic                   first_cand,
  input  logic [SW-1:0]          ref_s,
  input  logic [SW-1:0]          seg_s,
  input  logic signed [SH_W-1:0] cand_shift,
  output logic [SAD_W-1:0]       acc,
  output logic [SAD_W-1:0]       acc_nxt,
  output logic [SAD_W-1:0]       best_sad,
  output logic signed [SH_W-1:0] best_shift
);

  logic [SW:0] term;
  logic        take;

  assign term    = (SW + 1)'(sad_abs(int'($signed(seg_s)), int'($signed(ref_s))));
  assign acc_nxt = acc + SAD_W'(term);
  assign take    = step && win_end && (first_cand || (acc_nxt < best_sad));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc        <= '0;
      best_sad   <= '0;
      best_shift <= '0;
    end else if (clr) begin
      acc        <= '0;
      best_sad   <= '0;
      best_shift <= '0;
    end else if (step) begin
      acc <= win_end ? '0 : acc_nxt;
      if (take) begin
        best_sad   <= acc_nxt;
        best_shift <= cand_shift;
      end
    end
  end

endmodule

// File: rtl/sad_window_aligner.sv
module sad_window_aligner
  import sad_align_pkg::*;
#(
  parameter int SW        = 8,
  parameter int WIN       = 16,
  parameter int MAX_SHIFT = 4,
  localparam int SEG_LEN  = WIN + 2 * MAX_SHIFT,
  localparam int NCAND    = 2 * MAX_SHIFT + 1,
  localparam int SAD_W    = SW + $clog2(WIN),
  localparam int SH_W     = $clog2(MAX_SHIFT + 1) + 1,
  localparam int EW       = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int CW       = $clog2(NCAND),
  localparam int IW_S     = $clog2(SEG_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SAD_W-1:0] cfg_max_sad,
  input  logic             ref_valid,
  input  logic [SW-1:0]    ref_data,
  input  logic             seg_valid,
  input  logic [SW-1:0]    seg_data,
  output logic             done,
  output logic             match,
  output logic [SH_W-1:0]  best_shift,
  output logic [SAD_W-1:0] best_sad
);

  logic                   ref_we, seg_we, ref_last, seg_last;
  logic                   scan_step, win_end, scan_last, first_cand;
  logic [EW-1:0]          elem;
  logic [CW-1:0]          cand;
  logic [SW-1:0]          ref_q, seg_q;
  logic [IW_S-1:0]        seg_ra;
  logic signed [SH_W-1:0] cand_shift;
  logic signed [SH_W-1:0] best_shift_s;
  logic [SAD_W-1:0]       acc, acc_nxt;
  logic [SAD_W-1:0]       thr_q;

  assign cand_shift = SH_W'(cand_to_shift(int'(cand)));
  assign seg_ra     = IW_S'(int'(elem) + cand_to_shift(int'(cand)) + MAX_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= '0;
    else if (start) thr_q <= cfg_max_sad;
  end

  sad_sample_store #(.SW(SW), .WIN(WIN), .SEG_LEN(SEG_LEN)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(start),
    .ref_we(ref_we), .ref_d(ref_data),
    .seg_we(seg_we), .seg_d(seg_data),
    .ref_ra(elem), .seg_ra(seg_ra),
    .ref_q(ref_q), .seg_q(seg_q),
    .ref_last(ref_last), .seg_last(seg_last)
  );

  sad_scan_ctrl #(.WIN(WIN), .MAX_SHIFT(MAX_SHIFT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ref_valid(ref_valid), .seg_valid(seg_valid),
    .ref_last(ref_last), .seg_last(seg_last),
    .ref_we(ref_we), .seg_we(seg_we),
    .scan_step(scan_step), .win_end(win_end), .scan_last(scan_last),
    .first_cand(first_cand), .elem(elem), .cand(cand), .done(done)
  );

  sad_best_track #(.SW(SW), .SAD_W(SAD_W), .SH_W(SH_W)) u_best (
    .clk(clk), .rst_n(rst_n), .clr(start),
    .step(scan_step), .win_end(win_end), .first_cand(first_cand),
    .ref_s(ref_q), .seg_s(seg_q), .cand_shift(cand_shift),
    .acc(acc), .acc_nxt(acc_nxt),
    .best_sad(best_sad), .best_shift(best_shift_s)
  );

  assign best_shift = best_shift_s;
  assign match      = done && (best_sad <= thr_q);

endmodule

// File: rtl/sad_aligner_checker.sv
module sad_aligner_checker #(
  parameter int SAD_W     = 12,
  parameter int SH_W      = 4,
  parameter int MAX_SHIFT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done,
  input logic             match,
  input logic [SH_W-1:0]  best_shift,
  input logic [SAD_W-1:0] best_sad,
  input logic             scan_step,
  input logic             scan_last,
  input logic             first_cand,
  input logic [SAD_W-1:0] acc,
  input logic [SAD_W-1:0] acc_nxt,
  input logic             ref_we,
  input logic             seg_we
);

  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);

  p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(best_shift) && $stable(best_sad) && $stable(match)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_step |-> (acc_nxt >= acc));

  p_shift_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($signed(best_shift) >= -MAX_SHIFT && $signed(best_shift) <= MAX_SHIFT));

  p_best_falls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_step && !first_cand) |=> (best_sad <= $past(best_sad)));

  p_done_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(scan_step && scan_last));

  p_load_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_we && seg_we));

endmodule

bind sad_window_aligner sad_aligner_checker #(
  .SAD_W(SAD_W), .SH_W(SH_W), .MAX_SHIFT(MAX_SHIFT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .match(match),
  .best_shift(best_shift), .best_sad(best_sad),
  .scan_step(scan_step), .scan_last(scan_last), .first_cand(first_cand),
  .acc(acc), .acc_nxt(acc_nxt), .ref_we(ref_we), .seg_we(seg_we)
);

// File: tb/tb_sad_window_aligner.sv
module tb_sad_window_aligner;
  localparam int SW = 8, WIN = 16, S = 4;
  localparam int SEG = WIN + 2 * S;
  localparam int SAD_W = SW + $clog2(WIN);
  localparam int SH_W = $clog2(S + 1) + 1;
  localparam int LAT = (2 * S + 1) * WIN;
  // {kind, true shift, threshold}
  localparam int NV = 9;
  localparam int VEC [NV][3] = '{
    '{0, 2, 0}, '{0, -3, 0}, '{0, 4, 100}, '{1, -1, 40}, '{1, 1, 0},
    '{2, 0, 4095}, '{3, 0, 100}, '{4, 0, 0}, '{5, 0, 10}
  };

  logic clk = 0, rst_n = 0, start = 0, ref_valid = 0, seg_valid = 0;
  logic [SAD_W-1:0] cfg_max_sad = '0;
  logic [SW-1:0] ref_data = '0, seg_data = '0;
  logic done, match;
  logic [SH_W-1:0] best_shift;
  logic [SAD_W-1:0] best_sad;

  int ref_a [WIN];
  int seg_a [SEG];
  int total = 0, fails = 0, cyc = 0, lat;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  sad_window_aligner #(.SW(SW), .WIN(WIN), .MAX_SHIFT(S)) dut (.*);

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pat(input int x);
    return (((x + 100) * (x + 100) * 13 + (x + 100) * 29 + 7) % 256) - 128;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic build(input int kind, input int k);
    for (int i = 0; i < WIN; i++) ref_a[i] = pat(i);
    for (int j = 0; j < SEG; j++) begin
      case (kind)
        0: seg_a[j] = pat(j - S - k);
        1: seg_a[j] = pat(j - S - k) + ((j * 7) % 7 == 0 ? 2 : ((j * 5) % 7) - 3);
        5: seg_a[j] = pat(j * 3 + 41);
        default: seg_a[j] = 0;
      endcase
      if (seg_a[j] > 127) seg_a[j] = 127;
      if (seg_a[j] < -128) seg_a[j] = -128;
    end
    if (kind == 2) begin
      for (int i = 0; i < WIN; i++) ref_a[i] = -128;
      for (int j = 0; j < SEG; j++) seg_a[j] = 127;
    end
    if (kind == 3 || kind == 4) begin
      for (int i = 0; i < WIN; i++) ref_a[i] = 0;
      if (kind == 3) begin
        for (int j = 0; j < SEG; j++) seg_a[j] = (j <= 2 || j >= 21) ? 100 : 0;
        seg_a[4] = 50;
        seg_a[19] = 50;
      end
    end
  endtask

  // Independent search: lowest score, then smaller |shift|, then negative.
  task automatic model(output int bs, output int bsad);
    bs = 0; bsad = -1;
    for (int k = -S; k <= S; k++) begin
      int s = 0;
      for (int i = 0; i < WIN; i++) s += iabs(seg_a[i + k + S] - ref_a[i]);
      if (bsad < 0 || s < bsad || (s == bsad && (iabs(k) < iabs(bs) ||
          (iabs(k) == iabs(bs) && k < bs)))) begin
        bs = k; bsad = s;
      end
    end
  endtask

  task automatic run(input int thr, input bit junk);
    @(negedge clk);
    start = 1; cfg_max_sad = SAD_W'(thr);
    @(negedge clk);
    start = 0;
    for (int i = 0; i < WIN; i++) begin
      ref_valid = 1; ref_data = SW'(ref_a[i]);
      seg_valid = junk; seg_data = 8'h5A;
      @(negedge clk);
      ref_valid = 0; seg_valid = 0;
      if (junk) @(negedge clk);
    end
    for (int j = 0; j < SEG; j++) begin
      seg_valid = 1; seg_data = SW'(seg_a[j]);
      ref_valid = junk; ref_data = 8'hA5;
      if (j == SEG - 1) begin
        @(negedge clk);
      end else begin
        @(negedge clk);
        seg_valid = 0; ref_valid = 0;
        if (junk) @(negedge clk);
      end
    end
    seg_valid = 0; ref_valid = 0;
    lat = 0;
    while (!done && lat < 4 * LAT) begin
      @(posedge clk); lat++; @(negedge clk);
    end
  endtask

  task automatic check_result(input string req, input int thr);
    int es, esad;
    model(es, esad);
    check({req, " shift"}, int'($signed(best_shift)), es);
    check({req, " sad"}, int'(best_sad), esad);
    check({req, " match R6"}, int'(match), int'(esad <= thr));
  endtask

  initial begin
    #1000000;
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int es, esad;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 done", int'(done), 0);
    check("R1 match", int'(match), 0);
    check("R1 shift", int'(best_shift), 0);
    check("R1 sad", int'(best_sad), 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R4 R6 R7: table of cases
    for (int v = 0; v < NV; v++) begin
      build(VEC[v][0], VEC[v][1]);
      run(VEC[v][2], 1'b0);
      check("R7 latency", lat, LAT);
      check_result("R2 R4", VEC[v][2]);
      if (VEC[v][0] == 0) check("R4 true shift", int'($signed(best_shift)), VEC[v][1]);
      if (VEC[v][0] == 2) check("R3 full-scale sad", int'(best_sad), WIN * 255);
      if (VEC[v][0] == 3) check("R5 tie picks -1", int'($signed(best_shift)), -1);
      if (VEC[v][0] == 4) check("R5 all equal picks 0", int'($signed(best_shift)), 0);
    end

    // R8: hold, then start drops done
    es = int'($signed(best_shift)); esad = int'(best_sad);
    repeat (20) @(negedge clk);
    check("R8 done held", int'(done), 1);
    check("R8 shift held", int'($signed(best_shift)), es);
    check("R8 sad held", int'(best_sad), esad);
    start = 1;
    @(negedge clk);
    start = 0;
    check("R8 done cleared", int'(done), 0);

    // R9: wrong-phase strobes ignored
    build(0, -2);
    run(0, 1'b1);
    check_result("R9", 0);
    check("R9 shift", int'($signed(best_shift)), -2);

    // R10 / R6 boundary: two passes, limits at and below the score
    build(1, 3);
    model(es, esad);
    run(esad, 1'b0);
    check("R10 pass at limit match", int'(match), 1);
    run(esad - 1, 1'b0);
    check("R10 pass below limit match", int'(match), 0);
    check("R6 shift reported on reject", int'($signed(best_shift)), es);
    check("R6 sad reported on reject", int'(best_sad), esad);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule